// File: doc/BRIEF.md
# RTC Update-Cycle Timer with Drift Compensation

This block times the once-per-second update of a real-time clock. It counts enable pulses from a 32.768 kHz reference and emits a one-cycle update strobe after each full second, a nominal 32768 reference periods. The calendar, alarm and interrupt logic elsewhere on the chip consume that strobe.

An oscillator that runs fast or slow can be trimmed once per hour. An internal seconds counter spans one hour of update cycles. When auto-compensation is enabled, the last cycle of each hour is made shorter or longer by a signed 16-bit count of reference periods. A positive value shortens that cycle and a negative value lengthens it.

A busy flag rises a fixed number of system-clock cycles before every update strobe. This warns software that the time values are about to change. That lead is set by a parameter and is checked at elaboration against a 15 µs ceiling at the stated system-clock frequency.

Top module: `rtc_update_timer`

## Requirements
- R1: While `run` is low, or on the edge after `rst`, the period and seconds counters are cleared and `updPulse` and `busy` are low. When `run` rises, the first update comes after exactly NOMINAL_PERIODS counted ticks, and ticks seen while `run` is low are ignored.
- R2: With `autoComp` low, every update cycle lasts exactly NOMINAL_PERIODS reference ticks.
- R3: With `autoComp` high, only the cycle in which the seconds counter holds SECONDS_PER_HOUR-1 (the one ending at its wrap) is compensated. Its length is NOMINAL_PERIODS minus `compVal`, read as two's complement, so a positive value such as 0x0002 shortens it.
- R4: A negative `compVal`, such as 0xFFFE (-2), lengthens the compensated cycle by its magnitude.
- R5: `compVal` and `autoComp` are sampled on the edge that starts the compensated cycle. Changing them during that cycle does not alter its length.
- R6: A compensated length that works out to zero or less is replaced by one tick.
- R7: `updPulse` is one system clock wide. It is high exactly BUSY_LEAD cycles after the cycle in which `busy` rose (or after the cycle that follows the previous pulse, when busy is held).
- R8: `busy` stays high from its rise through the cycle of `updPulse`. It falls on the next edge unless another cycle ends on that edge.
- R9: If a cycle-ending tick lands on the edge where a pulse is output, `busy` stays high without a gap, and a new lead window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refTick | input | 1 | One-cycle enable per reference period |
| run | input | 1 | Counting enable; low holds everything cleared |
| autoComp | input | 1 | Enables hourly drift compensation |
| compVal | input | COMP_W | Signed reference periods subtracted from the compensated cycle |
| updPulse | output | 1 | One-cycle update strobe |
| busy | output | 1 | High from BUSY_LEAD cycles before the strobe through the strobe |

## Verification
The end of one busy window can coincide with the start of the next, when the update strobe of one cycle and the final tick of the next land on the same edge. The bench provokes this by forcing a compensated length of one tick with ticks spaced exactly BUSY_LEAD+1 cycles apart. It then checks, against its own behavioural model and a gap monitor, that `busy` never drops between the two windows and that both strobes still appear with the full lead.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;   // hold both counters at zero
    logic count;   // a reference tick is to be counted
  } dpStrobe_t;
endpackage

// File: rtl/rtc_upd_datapath.sv
module rtc_upd_datapath
  import rtc_upd_pkg::*;
#(
  parameter int NOMINAL_PERIODS  = 32768,
  parameter int SECONDS_PER_HOUR = 3600,
  parameter int COMP_W           = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         stb,
  input  logic              autoComp,
  input  logic [COMP_W-1:0] compVal,
  output logic              cycleEnd
);
  localparam int CNT_W = $clog2(NOMINAL_PERIODS + (1 << (COMP_W - 1)) + 1);
  localparam int EXT_W = CNT_W + 1;
  localparam int SEC_W = $clog2(SECONDS_PER_HOUR + 1);
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECONDS_PER_HOUR - 1);

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] targetLen;
  logic [SEC_W-1:0] secCnt;
  logic [SEC_W-1:0] nextSec;
  logic [CNT_W-1:0] tgtFirst;
  logic [CNT_W-1:0] tgtNext;

  // Length of the cycle that begins with the seconds counter at 'sec'
  function automatic logic [CNT_W-1:0] cycleLen(input logic [SEC_W-1:0] sec,
                                                input logic ena,
                                                input logic [COMP_W-1:0] c);
    logic [EXT_W-1:0] diff;
    diff = {1'b0, CNT_W'(NOMINAL_PERIODS)} -
           {{(EXT_W - COMP_W){c[COMP_W-1]}}, c};
    if (!(ena && sec == LAST_SEC))
      return CNT_W'(NOMINAL_PERIODS);
    else if (diff[EXT_W-1] || diff == '0)
      return CNT_W'(1);
    else
      return diff[CNT_W-1:0];
  endfunction

  always_comb begin
    nextSec  = (secCnt == LAST_SEC) ? '0 : secCnt + SEC_W'(1);
    tgtFirst = cycleLen('0, autoComp, compVal);
    tgtNext  = cycleLen(nextSec, autoComp, compVal);
    cycleEnd = stb.count && (periodCnt == targetLen - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clear) begin
      periodCnt <= '0;
      secCnt    <= '0;
      targetLen <= tgtFirst;
    end else if (cycleEnd) begin
      periodCnt <= '0;
      secCnt    <= nextSec;
      targetLen <= tgtNext;
    end else if (stb.count) begin
      periodCnt <= periodCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_upd_control.sv
module rtc_upd_control
  import rtc_upd_pkg::*;
#(
  parameter int BUSY_LEAD = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      refTick,
  input  logic      cycleEnd,
  output dpStrobe_t stb,
  output logic      updPulse,
  output logic      busy
);
  localparam int LEAD_W = $clog2(BUSY_LEAD + 1);
  localparam logic [LEAD_W-1:0] LEAD = LEAD_W'(BUSY_LEAD);

  logic [LEAD_W-1:0] leadCnt;
  logic              pulseQ;

  always_comb begin
    stb.clear = !run;
    stb.count = run && refTick;
    updPulse  = pulseQ;
    busy      = (leadCnt != '0) || pulseQ;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      leadCnt <= '0;
      pulseQ  <= 1'b0;
    end else begin
      pulseQ <= (leadCnt == LEAD_W'(1));
      if (cycleEnd)
        leadCnt <= LEAD;
      else if (leadCnt != '0)
        leadCnt <= leadCnt - LEAD_W'(1);
    end
  end
endmodule

// File: rtl/rtc_update_timer.sv
module rtc_update_timer
  import rtc_upd_pkg::*;
#(
  parameter int NOMINAL_PERIODS  = 32768,
  parameter int SECONDS_PER_HOUR = 3600,
  parameter int COMP_W           = 16,
  parameter int BUSY_LEAD        = 16,
  parameter int SYS_CLK_HZ       = 250_000_000,
  parameter int BUSY_MAX_NS      = 15_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refTick,
  input  logic              run,
  input  logic              autoComp,
  input  logic [COMP_W-1:0] compVal,
  output logic              updPulse,
  output logic              busy
);
  localparam longint LEAD_NS_X = longint'(BUSY_LEAD) * 64'd1_000_000_000;
  localparam longint LIMIT_X   = longint'(BUSY_MAX_NS) * longint'(SYS_CLK_HZ);

  generate
    if (BUSY_LEAD < 1 || LEAD_NS_X > LIMIT_X) begin : g_leadBad
      $error("BUSY_LEAD must be at least 1 and within BUSY_MAX_NS");
    end
  endgenerate

  dpStrobe_t stb;
  logic      cycleEnd;

  rtc_upd_control #(.BUSY_LEAD(BUSY_LEAD)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .refTick(refTick), .cycleEnd(cycleEnd),
    .stb(stb), .updPulse(updPulse), .busy(busy)
  );

  rtc_upd_datapath #(
    .NOMINAL_PERIODS(NOMINAL_PERIODS), .SECONDS_PER_HOUR(SECONDS_PER_HOUR),
    .COMP_W(COMP_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .autoComp(autoComp), .compVal(compVal),
    .cycleEnd(cycleEnd)
  );
endmodule

// File: rtl/rtc_upd_checker.sv
module rtc_upd_checker #(
  parameter int BUSY_LEAD = 16
) (
  input logic clk,
  input logic rst,
  input logic run,
  input logic updPulse,
  input logic busy
);
  localparam int W = $clog2(BUSY_LEAD + 2) + 1;

  logic         prevBusy, prevPulse, winStart;
  logic [W-1:0] winCnt, winCur;

  always_comb begin
    winStart = busy && (!prevBusy || prevPulse);
    winCur   = winStart ? '0 : winCnt + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBusy  <= 1'b0;
      prevPulse <= 1'b0;
      winCnt    <= '0;
    end else begin
      prevBusy  <= busy;
      prevPulse <= updPulse;
      winCnt    <= busy ? winCur : '0;
    end
  end

  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!updPulse && !busy));                                  // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    updPulse |=> !updPulse);                                         // R7
  AST_PULSE_LEAD: assert property (@(posedge clk) disable iff (rst)
    updPulse |-> (prevBusy && winCur == W'(BUSY_LEAD)));             // R7
  AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    updPulse |-> busy);                                              // R8
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(updPulse) || !$past(run)));               // R8
endmodule

bind rtc_update_timer rtc_upd_checker #(.BUSY_LEAD(BUSY_LEAD)) u_chk (
  .clk(clk), .rst(rst), .run(run), .updPulse(updPulse), .busy(busy)
);

// File: tb/rtc_update_timer_bench.sv
`timescale 1ns/1ps
module rtc_update_timer_bench;
  localparam int NOM  = 16;
  localparam int SPH  = 3;
  localparam int LEAD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refTick = 1'b0;
  logic run = 1'b0;
  logic autoComp = 1'b0;
  logic [15:0] compVal = '0;
  logic updPulse, busy;

  always #2 clk = ~clk;

  rtc_update_timer #(
    .NOMINAL_PERIODS(NOM), .SECONDS_PER_HOUR(SPH), .COMP_W(16), .BUSY_LEAD(LEAD)
  ) u_rtc_update_timer (
    .clk(clk), .rst(rst), .refTick(refTick), .run(run), .autoComp(autoComp),
    .compVal(compVal), .updPulse(updPulse), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mTicks, mSecs, mTgt, mRem;
  bit mPulse, mEnd;

  function automatic int lenFor(int s);
    int d;
    if (autoComp && s == SPH - 1) begin
      d = NOM - int'($signed(compVal));
      return (d < 1) ? 1 : d;
    end
    return NOM;
  endfunction

  // Observed cycle lengths, in ticks between strobes
  int lens[$];
  int tickSince;

  always @(posedge clk) begin
    if (rst || !run) begin
      mTicks = 0; mSecs = 0; mTgt = lenFor(0); mRem = 0; mPulse = 0;
      tickSince = 0;
    end else begin
      mEnd   = refTick && (mTicks + 1 == mTgt);
      mPulse = (mRem == 1);
      if (mRem > 0) mRem--;
      if (mEnd) begin
        mRem = LEAD; mTicks = 0; mSecs = (mSecs + 1) % SPH; mTgt = lenFor(mSecs);
      end else if (refTick) mTicks++;
      if (refTick) tickSince++;
    end
  end

  // Per-clock comparison plus lead and gap monitors
  bit prevB = 0, prevP = 0, gapSeen = 0, watchGap = 0;
  int winAge = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(updPulse), int'(mPulse), "R1 R7 updPulse vs model");
      check(int'(busy), int'((mRem != 0) || mPulse), "R8 R9 busy vs model");
      if (busy && (!prevB || prevP)) winAge = 0;
      else if (busy) winAge++;
      if (updPulse) check(winAge, LEAD, "R7 busy lead before strobe");
      if (watchGap && !busy) gapSeen = 1;
      if (updPulse) begin
        lens.push_back(tickSince);
        tickSince = 0;
      end
      prevB = busy; prevP = updPulse;
    end
  end

  task automatic step();
    @(posedge clk); #0.5;
  endtask

  task automatic oneTick(input int gap);
    refTick = 1'b0;
    repeat (gap - 1) step();
    refTick = 1'b1;
    step();
    refTick = 1'b0;
  endtask

  task automatic startPhase(input logic ac, input logic [15:0] cv);
    run = 1'b0;
    repeat (3) step();
    lens.delete();
    autoComp = ac; compVal = cv;
    run = 1'b1;
  endtask

  task automatic runUntil(input int n, input int gmin, input int gmax);
    while (lens.size() < n) oneTick(int'($urandom_range(gmax, gmin)));
    repeat (LEAD + 2) step();
  endtask

  task automatic checkHour(input int n, input int compLen, input string tag);
    check(lens.size(), n, {tag, " strobe count"});
    for (int i = 0; i < n && i < lens.size(); i++)
      check(lens[i], (i % SPH == SPH - 1) ? compLen : NOM, {tag, " cycle length"});
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) step();
    check(int'(updPulse), 0, "R1 reset updPulse");
    check(int'(busy), 0, "R1 reset busy");
    rst = 1'b0;
    // R1: ticks ignored while stopped
    for (int i = 0; i < 40; i++) oneTick(2);
    repeat (LEAD + 2) step();
    check(lens.size(), 0, "R1 no strobe while stopped");

    // R2: compensation disabled
    startPhase(1'b0, 16'h0002);
    runUntil(6, 4, 6);
    checkHour(6, NOM, "R2");

    // R3: positive value shortens
    startPhase(1'b1, 16'h0002);
    runUntil(6, 4, 6);
    checkHour(6, NOM - 2, "R3");

    // R4: negative value lengthens
    startPhase(1'b1, 16'hFFFE);
    runUntil(6, 4, 6);
    checkHour(6, NOM + 2, "R4");
    startPhase(1'b1, 16'hFC18);           // -1000
    runUntil(3, 4, 4);
    checkHour(3, NOM + 1000, "R4 large");

    // R5: changes inside the compensated cycle have no effect on it
    startPhase(1'b1, 16'h0003);
    while (lens.size() < 2) oneTick(5);
    compVal = 16'h0009; autoComp = 1'b0;
    runUntil(6, 4, 6);
    check(lens.size(), 6, "R5 strobe count");
    check(lens[2], NOM - 3, "R5 sampled length");
    check(lens[5], NOM, "R5 next hour uses new setting");

    // R6 and R9: clamp to one tick, strobe edge meets next cycle end
    startPhase(1'b1, 16'd100);
    while (lens.size() < 2) oneTick(4);
    watchGap = 1; gapSeen = 0;
    while (lens.size() < 3) oneTick(4);
    watchGap = 0;
    repeat (LEAD + 2) step();
    checkHour(3, 1, "R6");
    check(int'(gapSeen), 0, "R9 busy continuous across windows");
    startPhase(1'b1, 16'd16);
    runUntil(3, 4, 5);
    checkHour(3, 1, "R6 zero length");

    // R1: stop mid-cycle restarts the count
    startPhase(1'b0, 16'h0000);
    for (int i = 0; i < 7; i++) oneTick(4);
    run = 1'b0;
    step();
    run = 1'b1;
    runUntil(2, 4, 6);
    check(lens[0], NOM, "R1 restart after stop");
    check(lens[1], NOM, "R1 second cycle after restart");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule